// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block runs the transmit side of a network controller's descriptor ring. Software owns a small descriptor store inside the block. Each entry holds a five-bit status field, a byte count and a buffer address. Software hands an entry to the engine by setting its ready flag. The engine walks the entries in order. For each ready entry it reads the referenced bytes from a synchronous buffer RAM and presents them one per beat on a valid/ready byte stream. When the frame is done, it clears the ready flag, which hands the entry back to software.

The engine comes out of reset halted and fetches nothing until software pulses a clear-halt command. It halts again on its own when it meets an entry that is not ready. The next clear-halt resumes from that same entry. A wrap flag in an entry sends the walk back to entry 0 after that entry.

A graceful-stop request lets the frame in progress finish and then parks the engine. The engine signals that it is parked by setting an event bit. Software must drop the request before any further frame can go out. The per-frame flags for last buffer, append CRC and interrupt on completion travel alongside every byte as sideband. Event bits are cleared by writing one to them.

Top module: `tbd_tx_engine`

## Requirements
- R1: After reset, `halted` is 1, `tx_valid` and `buf_rd` are 0, `evt_out` is 0, every descriptor entry reads back as 0, and the walk position is entry 0.
- R2: While halted, the engine issues no buffer read and no beat. A one-cycle `cmd_clr_halt` pulse resumes the walk at the entry where the engine last stopped. That is entry 0 after reset, not the ring base in general.
- R3: A descriptor word has this layout: bit 28 ready, bit 27 wrap, bit 26 last buffer, bit 25 append CRC, bit 24 interrupt, bits 23:12 length, bits 11:0 buffer address. For a ready entry of length N ≥ 1, the engine sends N beats. Beat k carries the buffer byte at address (pointer + k) modulo 2^12. `tx_last` is 1 only on beat N-1.
- R4: Every beat of a frame carries `tx_side` = {last buffer, append CRC, interrupt}, taken from that frame's status field.
- R5: After its last beat is accepted, the entry reads back with only the ready bit cleared. The walk then moves to the next entry, and entry 7 is followed by entry 0.
- R6: An entry with the wrap bit set is followed by entry 0, not by the next index.
- R7: When the engine reaches an entry whose ready bit is clear, it sets `halted` and sends nothing further.
- R8: A ready entry of length 0 produces no beat. It is still handed back with ready cleared, and the walk continues past it.
- R9: While `tx_valid` is 1 and `tx_ready` is 0, the engine holds `tx_valid`, `tx_data`, `tx_last` and `tx_side` unchanged.
- R10: If `gstop_req` rises while a frame is in flight, that frame still completes. The engine then parks and sets `evt_out[0]`. While parked it sends nothing, and `cmd_clr_halt` has no effect. Dropping `gstop_req` resumes the walk at the next entry.
- R11: Handing back an entry whose interrupt bit is set makes `evt_out[1]` 1.
- R12: Writing 1 to a bit of `evt_w1c` clears that event bit on the next cycle and leaves the other event bit unchanged.
- R13: `buf_rd` is a one-cycle request. The RAM returns the byte on `buf_data` on the next cycle and holds it until the next request. `buf_rd` and `tx_valid` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dsc_wr_en | input | 1 | Software write strobe into the descriptor store |
| dsc_wr_idx | input | 3 | Entry written |
| dsc_wr_data | input | 29 | Descriptor word written |
| dsc_rd_idx | input | 3 | Entry read back |
| dsc_rd_data | output | 29 | Read-back descriptor word (combinational) |
| cmd_clr_halt | input | 1 | Clear-halt command pulse |
| gstop_req | input | 1 | Graceful-stop request level |
| evt_w1c | input | 2 | Write-one-to-clear strobes for the event bits |
| evt_out | output | 2 | Bit 0 graceful stop done, bit 1 frame completed with interrupt flag |
| halted | output | 1 | Engine halted |
| buf_rd | output | 1 | Buffer RAM read request |
| buf_addr | output | 12 | Buffer RAM byte address |
| buf_data | input | 8 | Buffer RAM read data |
| tx_valid | output | 1 | Beat valid |
| tx_ready | input | 1 | Beat accepted |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_side | output | 3 | {last buffer, append CRC, interrupt} sideband |

## Verification
The bench makes the buffer address roll over from 0xFFF to 0x000 inside one frame. An adder without the modulo would read the wrong bytes. It places a zero-length entry mid-ring: a design that counted down from zero would stream thousands of bytes or stall there. It arms a ready entry just past a wrapped one, so an engine that ignored wrap would send the wrong frame. It clears an earlier entry's ready bit and checks that clear-halt resumes there, not at entry 0. Finally it raises graceful stop in mid-frame, pulses clear-halt while parked, and holds `tx_ready` low on a beat. A design that truncated the frame, let clear-halt override the stop, or changed data under backpressure would show a wrong byte, a premature last, or a beat while parked.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
   typedef enum logic [2:0] {
      ST_HALT  = 3'd0,
      ST_FETCH = 3'd1,
      ST_READ  = 3'd2,
      ST_SEND  = 3'd3,
      ST_DONE  = 3'd4,
      ST_PARK  = 3'd5
   } tbd_state_e;

   // status field is the top five bits of a descriptor word
   localparam int STAT_W    = 5;
   localparam int STAT_RDY  = 4;
   localparam int STAT_WRAP = 3;
   localparam int STAT_LAST = 2;
   localparam int STAT_CRC  = 1;
   localparam int STAT_IRQ  = 0;

   localparam int EVT_N     = 2;
   localparam int EVT_PARK  = 0;
   localparam int EVT_FRAME = 1;
endpackage

// File: rtl/tbd_desc_store.sv
module tbd_desc_store #(
   parameter int DEPTH = 8,
   parameter int DW    = 29,
   parameter int RDY   = 28,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_we,
   input  logic [IW-1:0] sw_idx,
   input  logic [DW-1:0] sw_data,
   input  logic [IW-1:0] rd_idx_a,
   output logic [DW-1:0] rd_data_a,
   input  logic [IW-1:0] rd_idx_b,
   output logic [DW-1:0] rd_data_b,
   input  logic          give_back,
   input  logic [IW-1:0] give_idx
);
   logic [DEPTH*DW-1:0] ent_flat;

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (sw_we && sw_idx == IW'(g)) begin
            q <= sw_data;            // software write wins over hand-back
         end else if (give_back && give_idx == IW'(g)) begin
            q[RDY] <= 1'b0;
         end
      end
      assign ent_flat[g*DW +: DW] = q;
   end

   always_comb begin
      rd_data_a = '0;
      rd_data_b = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (rd_idx_a == IW'(k)) rd_data_a = ent_flat[k*DW +: DW];
         if (rd_idx_b == IW'(k)) rd_data_b = ent_flat[k*DW +: DW];
      end
   end
endmodule

// File: rtl/tbd_ring_step.sv
module tbd_ring_step #(
   parameter int DEPTH = 8,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic [IW-1:0] cur,
   input  logic          wrap,
   output logic [IW-1:0] nxt
);
   localparam bit POW2 = (DEPTH == (1 << IW));

   if (POW2) begin : g_pow2
      // index rolls over naturally at the top entry
      assign nxt = wrap ? '0 : cur + 1'b1;
   end else begin : g_any
      assign nxt = (wrap || cur == IW'(DEPTH - 1)) ? '0 : cur + 1'b1;
   end
endmodule

// File: rtl/tbd_evt_reg.sv
module tbd_evt_reg #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] w1c,
   output logic [N-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~w1c) | set;
   end
endmodule

// File: rtl/tbd_tx_seq.sv
module tbd_tx_seq
   import tbd_pkg::*;
#(
   parameter int IW     = 3,
   parameter int LEN_W  = 12,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_halt,
   input  logic              gstop_req,
   input  logic              d_rdy,
   input  logic              d_wrap,
   input  logic              d_last,
   input  logic              d_crc,
   input  logic              d_irq,
   input  logic [LEN_W-1:0]  d_len,
   input  logic [ADDR_W-1:0] d_ptr,
   input  logic [IW-1:0]     nxt_idx,
   output logic [IW-1:0]     cur_idx,
   output logic              cur_wrap,
   output logic              give_back,
   output logic              set_park,
   output logic              set_frame,
   output logic              halted,
   output logic              buf_rd,
   output logic [ADDR_W-1:0] buf_addr,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic              tx_last,
   output logic [2:0]        tx_side
);
   tbd_state_e        st_q, st_d;
   logic [IW-1:0]     idx_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [LEN_W-1:0]  len_q, cnt_q;
   logic [2:0]        side_q;
   logic              wrap_q, irq_q;
   logic              final_beat;

   assign cur_idx    = idx_q;
   assign cur_wrap   = wrap_q;
   assign final_beat = (cnt_q + 1'b1) == len_q;

   always_comb begin
      st_d      = st_q;
      give_back = 1'b0;
      set_park  = 1'b0;
      set_frame = 1'b0;
      buf_rd    = 1'b0;
      tx_valid  = 1'b0;
      tx_last   = 1'b0;
      unique case (st_q)
         ST_HALT: begin
            if (gstop_req) begin
               st_d     = ST_PARK;
               set_park = 1'b1;
            end else if (clr_halt) begin
               st_d = ST_FETCH;
            end
         end
         ST_FETCH: begin
            if (gstop_req) begin
               st_d     = ST_PARK;
               set_park = 1'b1;
            end else if (!d_rdy) begin
               st_d = ST_HALT;
            end else if (d_len == '0) begin
               st_d = ST_DONE;
            end else begin
               st_d = ST_READ;
            end
         end
         ST_READ: begin
            buf_rd = 1'b1;
            st_d   = ST_SEND;
         end
         ST_SEND: begin
            tx_valid = 1'b1;
            tx_last  = final_beat;
            if (tx_ready) st_d = final_beat ? ST_DONE : ST_READ;
         end
         ST_DONE: begin
            give_back = 1'b1;
            set_frame = irq_q;
            if (gstop_req) begin
               st_d     = ST_PARK;
               set_park = 1'b1;
            end else begin
               st_d = ST_FETCH;
            end
         end
         ST_PARK: begin
            if (!gstop_req) st_d = ST_FETCH;
         end
         default: st_d = ST_HALT;
      endcase
   end

   assign halted   = (st_q == ST_HALT);
   assign buf_addr = ptr_q + ADDR_W'(cnt_q);
   assign tx_side  = side_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_HALT;
         idx_q  <= '0;
         ptr_q  <= '0;
         len_q  <= '0;
         cnt_q  <= '0;
         side_q <= '0;
         wrap_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_FETCH && st_d != ST_PARK && d_rdy) begin
            ptr_q  <= d_ptr;
            len_q  <= d_len;
            cnt_q  <= '0;
            side_q <= {d_last, d_crc, d_irq};
            wrap_q <= d_wrap;
            irq_q  <= d_irq;
         end
         if (st_q == ST_SEND && tx_ready && !final_beat) cnt_q <= cnt_q + 1'b1;
         if (st_q == ST_DONE) idx_q <= nxt_idx;
      end
   end
endmodule

// File: rtl/tbd_tx_engine.sv
module tbd_tx_engine
   import tbd_pkg::*;
#(
   parameter int RING_DEPTH = 8,
   parameter int LEN_W      = 12,
   parameter int ADDR_W     = 12,
   localparam int IW        = $clog2(RING_DEPTH),
   localparam int DESC_W    = STAT_W + LEN_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dsc_wr_en,
   input  logic [IW-1:0]     dsc_wr_idx,
   input  logic [DESC_W-1:0] dsc_wr_data,
   input  logic [IW-1:0]     dsc_rd_idx,
   output logic [DESC_W-1:0] dsc_rd_data,
   input  logic              cmd_clr_halt,
   input  logic              gstop_req,
   input  logic [1:0]        evt_w1c,
   output logic [1:0]        evt_out,
   output logic              halted,
   output logic              buf_rd,
   output logic [ADDR_W-1:0] buf_addr,
   input  logic [7:0]        buf_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [7:0]        tx_data,
   output logic              tx_last,
   output logic [2:0]        tx_side
);
   localparam int STAT_LSB = LEN_W + ADDR_W;

   if (RING_DEPTH < 2) begin : g_bad_depth
      $error("tbd_tx_engine: RING_DEPTH must be at least 2");
   end
   if (LEN_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("tbd_tx_engine: LEN_W and ADDR_W must be positive");
   end

   logic [DESC_W-1:0] cur_word;
   logic [IW-1:0]     cur_idx, nxt_idx;
   logic              cur_wrap, give_back, set_park, set_frame;
   logic [EVT_N-1:0]  evt_set;

   tbd_desc_store #(
      .DEPTH (RING_DEPTH),
      .DW    (DESC_W),
      .RDY   (STAT_LSB + STAT_RDY)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_we     (dsc_wr_en),
      .sw_idx    (dsc_wr_idx),
      .sw_data   (dsc_wr_data),
      .rd_idx_a  (dsc_rd_idx),
      .rd_data_a (dsc_rd_data),
      .rd_idx_b  (cur_idx),
      .rd_data_b (cur_word),
      .give_back (give_back),
      .give_idx  (cur_idx)
   );

   tbd_ring_step #(.DEPTH(RING_DEPTH)) u_step (
      .cur  (cur_idx),
      .wrap (cur_wrap),
      .nxt  (nxt_idx)
   );

   tbd_tx_seq #(
      .IW     (IW),
      .LEN_W  (LEN_W),
      .ADDR_W (ADDR_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_halt  (cmd_clr_halt),
      .gstop_req (gstop_req),
      .d_rdy     (cur_word[STAT_LSB + STAT_RDY]),
      .d_wrap    (cur_word[STAT_LSB + STAT_WRAP]),
      .d_last    (cur_word[STAT_LSB + STAT_LAST]),
      .d_crc     (cur_word[STAT_LSB + STAT_CRC]),
      .d_irq     (cur_word[STAT_LSB + STAT_IRQ]),
      .d_len     (cur_word[ADDR_W +: LEN_W]),
      .d_ptr     (cur_word[0 +: ADDR_W]),
      .nxt_idx   (nxt_idx),
      .cur_idx   (cur_idx),
      .cur_wrap  (cur_wrap),
      .give_back (give_back),
      .set_park  (set_park),
      .set_frame (set_frame),
      .halted    (halted),
      .buf_rd    (buf_rd),
      .buf_addr  (buf_addr),
      .tx_valid  (tx_valid),
      .tx_ready  (tx_ready),
      .tx_last   (tx_last),
      .tx_side   (tx_side)
   );

   always_comb begin
      evt_set            = '0;
      evt_set[EVT_PARK]  = set_park;
      evt_set[EVT_FRAME] = set_frame;
   end

   tbd_evt_reg #(.N(EVT_N)) u_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (evt_set),
      .w1c   (evt_w1c),
      .q     (evt_out)
   );

   // the buffer RAM holds its output until the next read, so beats come straight from it
   assign tx_data = tx_valid ? buf_data : 8'h00;
endmodule

// File: rtl/tbd_tx_engine_chk.sv
module tbd_tx_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       halted,
   input logic       buf_rd,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic [7:0] tx_data,
   input logic       tx_last,
   input logic [2:0] tx_side,
   input logic       gstop_req,
   input logic [1:0] evt_out
);
   a_r2_halted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!buf_rd && !tx_valid));

   a_r9_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=>
         (tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_side)));

   a_r10_park_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_out[0]) |-> $past(gstop_req));

   a_r13_rd_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(buf_rd && tx_valid));

   a_r3_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);
endmodule

bind tbd_tx_engine tbd_tx_engine_chk u_chk (.*);

// File: tb/tbd_tx_engine_bench.sv
module tbd_tx_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dsc_wr_en = 1'b0;
   logic [2:0]  dsc_wr_idx = '0;
   logic [28:0] dsc_wr_data = '0;
   logic [2:0]  dsc_rd_idx = '0;
   logic [28:0] dsc_rd_data;
   logic        cmd_clr_halt = 1'b0;
   logic        gstop_req = 1'b0;
   logic [1:0]  evt_w1c = '0;
   logic [1:0]  evt_out;
   logic        halted, buf_rd, tx_valid, tx_last;
   logic [11:0] buf_addr;
   logic [7:0]  buf_data = '0;
   logic        tx_ready = 1'b1;
   logic [7:0]  tx_data;
   logic [2:0]  tx_side;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   tbd_tx_engine u_tbd_tx_engine (.*);

   function automatic logic [7:0] pat(input int a);
      return 8'(((a & 12'hFFF) * 29 + 11) & 255);
   endfunction

   // buffer RAM model: data one cycle after a read, held until the next read
   always_ff @(posedge clk) if (buf_rd) buf_data <= pat(int'(buf_addr));

   function automatic logic [28:0] mk(input bit r, input bit w, input bit l, input bit c,
                                      input bit i, input int len, input int ptr);
      return {r, w, l, c, i, 12'(len), 12'(ptr)};
   endfunction

   // frame table: descriptor words for entries 0..3, walked by one loop
   localparam logic [28:0] VEC [4] = '{
      mk(1, 0, 1, 1, 0, 5, 12'h010),
      mk(1, 0, 0, 0, 1, 3, 12'h0F0),
      mk(1, 0, 0, 0, 0, 0, 12'h100),
      mk(1, 0, 1, 1, 0, 4, 12'hFFE)
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_desc(input int idx, input logic [28:0] w);
      @(negedge clk);
      dsc_wr_en = 1'b1; dsc_wr_idx = 3'(idx); dsc_wr_data = w;
      @(negedge clk);
      dsc_wr_en = 1'b0;
   endtask

   task automatic rd_desc(input int idx, output logic [28:0] w);
      dsc_rd_idx = 3'(idx);
      #1;
      w = dsc_rd_data;
   endtask

   task automatic pulse_clr();
      @(negedge clk); cmd_clr_halt = 1'b1;
      @(negedge clk); cmd_clr_halt = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // expects one frame; optionally raises graceful stop after the first beat
   task automatic expect_frame(input logic [28:0] w, input string req, input bit stop_mid);
      int len, ptr, g;
      len = int'(w[23:12]);
      ptr = int'(w[11:0]);
      for (int b = 0; b < len; b++) begin
         g = 0;
         while (!tx_valid && g < 200) begin @(negedge clk); g++; end
         chk(tx_valid, {req, " beat present"}, int'(tx_valid), 1);
         chk(tx_data == pat(ptr + b), {req, " data"}, int'(tx_data), int'(pat(ptr + b)));
         chk(tx_last == (b == len - 1), {req, " last"}, int'(tx_last), int'(b == len - 1));
         chk(tx_side == w[26:24], "R4 sideband", int'(tx_side), int'(w[26:24]));
         if (stop_mid && b == 0) gstop_req = 1'b1;
         @(negedge clk);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         n_bad++;
         $display("FAIL watchdog all-requirements actual=%0d expected<%0d", cyc, 100000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [28:0] w;
      int seen;
      idle(3);
      // R1: reset state
      chk(halted == 1'b1, "R1 halted", int'(halted), 1);
      chk(tx_valid == 1'b0 && buf_rd == 1'b0, "R1 idle", int'({tx_valid, buf_rd}), 0);
      chk(evt_out == 2'b00, "R1 events", int'(evt_out), 0);
      rst_n = 1'b1;
      idle(2);
      rd_desc(5, w);
      chk(w == '0, "R1 store clear", int'(w), 0);

      for (int k = 0; k < 4; k++) wr_desc(k, VEC[k]);

      // R2: no clear-halt, nothing happens
      seen = 0;
      repeat (20) begin @(negedge clk); if (tx_valid || buf_rd) seen++; end
      chk(seen == 0 && halted, "R2 stays halted", seen, 0);

      // table walk: R3 frames, R8 zero-length skipped, R5 hand-back
      pulse_clr();
      for (int k = 0; k < 4; k++) begin
         if (VEC[k][23:12] != 0) expect_frame(VEC[k], "R3", 1'b0);
      end
      idle(6);
      chk(halted == 1'b1, "R7 halt at non-ready entry", int'(halted), 1);
      for (int k = 0; k < 4; k++) begin
         rd_desc(k, w);
         chk(w == (VEC[k] & ~29'h1000_0000), "R5 ready cleared", int'(w), int'(VEC[k] & ~29'h1000_0000));
      end
      rd_desc(2, w);
      chk(w[28] == 1'b0, "R8 zero-length handed back", int'(w[28]), 0);
      chk(evt_out == 2'b10, "R11 irq event", int'(evt_out), 2);

      // R12: write-one-to-clear
      @(negedge clk); evt_w1c = 2'b10;
      @(negedge clk); evt_w1c = 2'b00;
      chk(evt_out == 2'b00, "R12 w1c", int'(evt_out), 0);

      // R6: wrap at entry 4 goes to entry 0, not entry 5
      wr_desc(4, mk(1, 1, 0, 0, 0, 2, 12'h200));
      wr_desc(5, mk(1, 0, 0, 0, 0, 2, 12'h300));
      wr_desc(0, mk(1, 0, 1, 0, 0, 3, 12'h400));
      pulse_clr();
      expect_frame(mk(1, 1, 0, 0, 0, 2, 12'h200), "R6 wrapped entry", 1'b0);
      expect_frame(mk(1, 0, 1, 0, 0, 3, 12'h400), "R6 after wrap", 1'b0);
      idle(6);
      chk(halted == 1'b1, "R7 halt at entry 1", int'(halted), 1);
      rd_desc(5, w);
      chk(w[28] == 1'b1, "R6 entry 5 skipped", int'(w[28]), 1);

      // R2 resume point and R9 backpressure
      tx_ready = 1'b0;
      wr_desc(1, mk(1, 0, 0, 1, 0, 2, 12'h500));
      pulse_clr();
      seen = 0;
      while (!tx_valid && seen < 50) begin @(negedge clk); seen++; end
      chk(tx_data == pat(12'h500), "R2 resume at entry 1", int'(tx_data), int'(pat(12'h500)));
      seen = 0;
      repeat (4) begin
         @(negedge clk);
         if (!tx_valid || tx_data != pat(12'h500) || tx_last) seen++;
      end
      chk(seen == 0, "R9 beat held", seen, 0);
      tx_ready = 1'b1;
      @(negedge clk);
      expect_frame(mk(1, 0, 0, 1, 0, 1, 12'h501), "R3 second beat", 1'b0);
      idle(6);
      chk(halted == 1'b1, "R7 halt at entry 2", int'(halted), 1);

      // R10: graceful stop mid-frame
      wr_desc(2, mk(1, 0, 0, 0, 0, 6, 12'h600));
      wr_desc(3, mk(1, 0, 0, 0, 0, 2, 12'h700));
      pulse_clr();
      expect_frame(mk(1, 0, 0, 0, 0, 6, 12'h600), "R10 frame completes", 1'b1);
      seen = 0;
      repeat (4) begin @(negedge clk); if (tx_valid || buf_rd) seen++; end
      @(negedge clk); cmd_clr_halt = 1'b1;
      @(negedge clk); cmd_clr_halt = 1'b0;
      repeat (6) begin @(negedge clk); if (tx_valid || buf_rd) seen++; end
      chk(seen == 0, "R10 parked silent", seen, 0);
      chk(evt_out[0] == 1'b1, "R10 park event", int'(evt_out), 1);
      chk(halted == 1'b0, "R10 parked not halted", int'(halted), 0);
      rd_desc(3, w);
      chk(w[28] == 1'b1, "R10 next entry untouched", int'(w[28]), 1);
      @(negedge clk); evt_w1c = 2'b01;
      @(negedge clk); evt_w1c = 2'b00;
      chk(evt_out == 2'b00, "R12 park event cleared", int'(evt_out), 0);
      gstop_req = 1'b0;
      expect_frame(mk(1, 0, 0, 0, 0, 2, 12'h700), "R10 resume", 1'b0);
      idle(6);
      chk(halted == 1'b1, "R7 halt at entry 4", int'(halted), 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule